// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block holds a three-field alarm setting (minute, hour, day) and compares it with the running calendar. The calendar supplies the current BCD minute, hour and date, a one-hot weekday and a strobe that marks each minute boundary, the cycle in which seconds have just become 00. On such a strobe, a full match of the alarm setting against the calendar sets a sticky alarm flag. An interrupt request follows the flag only while the alarm enable input is high.

The day field is read in one of two ways, chosen by a mode input. In date mode it is a BCD day of the month that must equal the current date. In weekday mode its low seven bits form a mask, and the day matches when the mask bit for the current weekday is set. One mask can therefore cover several weekdays. The three fields sit at consecutive write addresses so a host can load them as a burst. Software clears the flag with a one-cycle clear pulse.

Top module: `alarm_cmp_top`

## Requirements
- R1: After reset `af` and `irq` are 0 and all three alarm fields are 00h.
- R2: A write with `wr_en` high loads `wr_data` into the minute field at address 0, the hour field at address 1 or the day field at address 2. A write to address 3 changes no field.
- R3: In date mode (`date_mode`=1), a `min_tick` cycle in which `cur_min`, `cur_hour` and `cur_date` all equal the minute, hour and day fields sets `af` one cycle later.
- R4: In date mode, a `min_tick` whose date differs from the day field does not set `af`.
- R5: In weekday mode (`date_mode`=0), day-field bit i stands for weekday i (bit 0 is Sunday, bit 7 is unused). `cur_wday` is one-hot in the same order. A `min_tick` with minute and hour equal sets `af` when the bit for the current weekday is set.
- R6: In weekday mode, a `min_tick` whose weekday bit is clear in the mask does not set `af`, even when minute and hour match.
- R7: Without `min_tick` a matching time never sets `af`, so one alarm minute gives one event.
- R8: `af` stays 1 until a cycle with `af_clr` high clears it. A match on a tick in the same cycle as the clear wins, and `af` stays 1.
- R9: `irq` is 1 exactly when `af` is 1 and `alarm_en` is 1. With `alarm_en` low, `irq` stays 0 while `af` is set.
- R10: A `min_tick` on which the minute or the hour differs from its field does not set `af`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Alarm field write strobe |
| wr_addr | input | 2 | Field address: 0 minute, 1 hour, 2 day |
| wr_data | input | 8 | Field write data |
| date_mode | input | 1 | 1: day field is a BCD date; 0: weekday mask |
| alarm_en | input | 1 | Lets the flag drive the interrupt |
| af_clr | input | 1 | Clears the alarm flag |
| min_tick | input | 1 | Minute-boundary strobe from the calendar |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| cur_wday | input | 7 | Current weekday, one-hot |
| af | output | 1 | Sticky alarm flag |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties check on every cycle that the flag rises only after a tick, that it sets after a tick with a match, that it holds until a clear and drops after a clear with no competing match, and that a write to the spare address leaves the fields unchanged. Whether the day decode is correct in both modes needs bench scenarios. These include the leap-day rollover with date 1 against date 2, and a Tuesday mask seen on a Tuesday and on a Thursday. The bench also checks the interrupt gating and the burst load of the fields against its own model.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
    localparam int FIELD_W = 8;
    localparam int WDAY_N  = 7;
    localparam int NSLOT   = 3;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        SLOT_MIN  = 2'd0,
        SLOT_HOUR = 2'd1,
        SLOT_DAY  = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;

    typedef struct packed {
        logic af;
    } flag_state_t;
endpackage

// File: rtl/alarm_cmp_regs.sv
module alarm_cmp_regs
    import alarm_cmp_pkg::*;
#(
    parameter int W  = FIELD_W,
    parameter int AW = ADDR_W,
    parameter int NS = NSLOT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  alm_min,
    output logic [W-1:0]  alm_hour,
    output logic [W-1:0]  alm_day
);
    logic [W-1:0] slot_d [NS];
    logic [W-1:0] slot_q [NS];

    for (genvar g = 0; g < NS; g++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_addr == AW'(g));
        always_comb begin
            slot_d[g] = sel ? wr_data : slot_q[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < NS; i++) slot_q[i] <= slot_d[i];
        end
    end

    assign alm_min  = slot_q[SLOT_MIN];
    assign alm_hour = slot_q[SLOT_HOUR];
    assign alm_day  = slot_q[SLOT_DAY];

    // R2: the spare address disturbs no field
    p_spare_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SLOT_NONE) |=>
            ($stable(alm_min) && $stable(alm_hour) && $stable(alm_day)));
endmodule

// File: rtl/alarm_cmp_match.sv
module alarm_cmp_match
    import alarm_cmp_pkg::*;
#(
    parameter int W  = FIELD_W,
    parameter int WD = WDAY_N
) (
    input  logic [W-1:0]  alm_min,
    input  logic [W-1:0]  alm_hour,
    input  logic [W-1:0]  alm_day,
    input  logic [W-1:0]  cur_min,
    input  logic [W-1:0]  cur_hour,
    input  logic [W-1:0]  cur_date,
    input  logic [WD-1:0] cur_wday,
    input  logic          date_mode,
    output logic          hit
);
    logic time_eq;
    logic date_eq;
    logic wday_eq;

    always_comb begin
        time_eq = (alm_min == cur_min) && (alm_hour == cur_hour);
        date_eq = (alm_day == cur_date);
        wday_eq = |(alm_day[WD-1:0] & cur_wday);
        hit     = time_eq && (date_mode ? date_eq : wday_eq);
    end
endmodule

// File: rtl/alarm_cmp_flag.sv
module alarm_cmp_flag
    import alarm_cmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic min_tick,
    input  logic hit,
    input  logic af_clr,
    input  logic alarm_en,
    output logic af,
    output logic irq
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (min_tick && hit) st_d.af = 1'b1;
        else if (af_clr)     st_d.af = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign af  = st_q.af;
    assign irq = st_q.af & alarm_en;

    // R7: a rising flag is always preceded by a tick
    p_rise_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af) |-> $past(min_tick));
    // R3: tick with a match sets the flag
    p_match_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (min_tick && hit) |=> af);
    // R8: flag holds without a clear
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (af && !af_clr) |=> af);
    // R8: clear without a competing match drops the flag
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (af_clr && !(min_tick && hit)) |=> !af);
endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top
    import alarm_cmp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [FIELD_W-1:0]  wr_data,
    input  logic                date_mode,
    input  logic                alarm_en,
    input  logic                af_clr,
    input  logic                min_tick,
    input  logic [FIELD_W-1:0]  cur_min,
    input  logic [FIELD_W-1:0]  cur_hour,
    input  logic [FIELD_W-1:0]  cur_date,
    input  logic [WDAY_N-1:0]   cur_wday,
    output logic                af,
    output logic                irq
);
    logic [FIELD_W-1:0] alm_min, alm_hour, alm_day;
    logic hit;

    alarm_cmp_regs #(.W(FIELD_W), .AW(ADDR_W), .NS(NSLOT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alm_min(alm_min), .alm_hour(alm_hour),
        .alm_day(alm_day)
    );

    alarm_cmp_match #(.W(FIELD_W), .WD(WDAY_N)) u_match (
        .alm_min(alm_min), .alm_hour(alm_hour), .alm_day(alm_day),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .cur_wday(cur_wday), .date_mode(date_mode), .hit(hit)
    );

    alarm_cmp_flag u_flag (
        .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .hit(hit),
        .af_clr(af_clr), .alarm_en(alarm_en), .af(af), .irq(irq)
    );

    // R9: with the enable low, no request leaves the block
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_en |-> !irq);
endmodule

// File: tb/tb_alarm_cmp_top.sv
module tb_alarm_cmp_top;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0; logic [1:0] wr_addr = 0; logic [7:0] wr_data = 0;
    logic date_mode = 0, alarm_en = 0, af_clr = 0, min_tick = 0;
    logic [7:0] cur_min = 0, cur_hour = 0, cur_date = 0;
    logic [6:0] cur_wday = 0;
    logic af, irq;

    int total = 0, fails = 0;
    logic [7:0] m_alm [3];
    bit exp_af = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_cmp_top dut (.*);

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic bit model_hit(input logic [7:0] m, h, d, input int wd,
                                     input bit mode);
        bit day_ok;
        day_ok = mode ? (d == m_alm[2]) : m_alm[2][wd];
        return (m == m_alm[0]) && (h == m_alm[1]) && day_ok;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 0;
        if (a < 3) m_alm[a] = d;
    endtask

    task automatic step(input logic [7:0] m, h, d, input int wd, input bit mode,
                        en, tick, clr, input string tag);
        cur_min = m; cur_hour = h; cur_date = d; cur_wday = 7'(1 << wd);
        date_mode = mode; alarm_en = en; min_tick = tick; af_clr = clr;
        if (tick && model_hit(m, h, d, wd, mode)) exp_af = 1;
        else if (clr) exp_af = 0;
        @(posedge clk); @(negedge clk);
        min_tick = 0; af_clr = 0;
        chk(af == exp_af, {tag, " af"}, int'(af), int'(exp_af));
        chk(irq == (exp_af & en), {tag, " irq"}, int'(irq), int'(exp_af & en));
    endtask

    task automatic clear_flag();
        step(8'h99, 8'h99, 8'h99, 0, 1, 0, 0, 1, "clear");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) m_alm[i] = 0;
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        chk(af == 0 && irq == 0, "R1 reset outputs", int'({af, irq}), 0);
        rst_n = 1;
        @(negedge clk);
        // R1: fields are zero: 00:00 date 00 matches
        step(8'h00, 8'h00, 8'h00, 0, 1, 1, 1, 0, "R1 zero fields");
        clear_flag();

        // R2: burst load 00:00 day 01, spare address ignored
        wr(0, bcd(0)); wr(1, bcd(0)); wr(2, bcd(1)); wr(3, 8'h02);
        // R3: leap-day rollover to Mar 1 (Tuesday=2) fires in date mode
        step(bcd(0), bcd(0), bcd(1), 2, 1, 1, 1, 0, "R3 R2 date match");
        // R7: next minute without a match and no tick: no re-set after clear
        clear_flag();
        step(bcd(0), bcd(0), bcd(1), 2, 1, 1, 0, 0, "R7 no tick");
        step(bcd(1), bcd(0), bcd(1), 2, 1, 1, 1, 0, "R10 minute differs");
        step(bcd(0), bcd(1), bcd(1), 2, 1, 1, 1, 0, "R10 hour differs");
        // R4: day 2 alarm does not fire at Mar 1
        wr(2, bcd(2));
        step(bcd(0), bcd(0), bcd(1), 2, 1, 1, 1, 0, "R4 date miss");
        // R5 / R6: Tuesday mask
        wr(2, 8'h04);
        step(bcd(0), bcd(0), bcd(1), 4, 0, 1, 1, 0, "R6 thursday miss");
        step(bcd(0), bcd(0), bcd(1), 2, 0, 1, 1, 0, "R5 tuesday hit");
        // R8: sticky and set beats clear
        step(bcd(5), bcd(5), bcd(5), 3, 0, 1, 0, 0, "R8 sticky");
        step(bcd(0), bcd(0), bcd(1), 2, 0, 1, 1, 1, "R8 set wins");
        // R9: enable low masks irq
        step(bcd(5), bcd(5), bcd(5), 3, 0, 0, 0, 0, "R9 masked");
        chk(af == 1, "R9 flag kept", int'(af), 1);
        clear_flag();
        // R5: multi-bit mask
        wr(2, 8'h41);
        step(bcd(0), bcd(0), bcd(9), 6, 0, 1, 1, 0, "R5 saturday bit");

        for (int it = 0; it < 400; it++) begin
            logic [7:0] m, h, d; int wd; bit mode;
            if ($urandom_range(0, 3) == 0)
                wr(2'($urandom_range(0, 3)), 8'($urandom));
            mode = 1'($urandom);
            wd = $urandom_range(0, 6);
            if ($urandom_range(0, 1) == 1) begin
                m = m_alm[0]; h = m_alm[1]; d = m_alm[2];
                if (!mode && m_alm[2][6:0] != 0)
                    while (!m_alm[2][wd]) wd = $urandom_range(0, 6);
            end else begin
                m = bcd($urandom_range(0, 59)); h = bcd($urandom_range(0, 23));
                d = bcd($urandom_range(1, 31));
            end
            step(m, h, d, wd, mode, 1'($urandom), 1'($urandom_range(0, 4) != 0),
                 1'($urandom_range(0, 2) == 0), "R3 R5 R8 random");
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule